// File: doc/BRIEF.md
# Master/Word Clock Ratio Detector and Startup Sequencer

This block runs on the master clock and watches an incoming word (frame) clock. It measures each word-clock period in master-clock cycles and classifies it as one of three supported ratios (256, 384 or 512 master cycles per word). A valid ratio takes the block out of power-down. It then steps through an initialisation phase and a calibration phase, each a fixed number of word periods long, and then reaches normal running. A measured period that disagrees with the locked ratio, or a word clock that goes silent, sends it straight back to power-down. Detection starts again from there.

Alongside the sequencer, the block decides where the serial bit clock comes from. A bit-clock input that toggles often enough within a single word-clock half-period latches an external-clock mode, and only power-down clears it. Otherwise the block produces its own bit clock from the master clock: 64 cycles per word period, phase-aligned to the word-clock rising edge. A change on the two format-select inputs that is held long enough requests a new calibration pass.

All inputs other than the master clock are treated as asynchronous and pass through a synchronizer before use.

Top module: `clkratio_seq`

## Requirements
- R1: While reset is high, and after reset until a valid ratio is measured, `pwr_down` is 1, `initing`, `calibrating`, `running`, `ext_bclk` and `bclk_int` are 0, and `ratio_code` is 0. With no word-clock edges the block stays powered down indefinitely.
- R2: `ratio_code` reports the locked ratio as 1 for 256, 2 for 384 and 3 for 512 master cycles per word period. It does not change while the block is out of power-down.
- R3: The first valid period measurement moves the block to initialisation. It stays there for exactly INIT_PERIODS word periods, then in calibration for exactly CAL_PERIODS word periods, then in running. Exactly one of the four state flags is high at any time.
- R4: A measured period is valid when it lies within RATIO_TOL (default 4) cycles of 256, 384 or 512. A word clock of any other period keeps the block in power-down.
- R5: Outside power-down, a period measurement that differs from the locked ratio returns the block to power-down. Detection then restarts, and the new ratio is locked on its first valid measurement.
- R6: When not powered down and not in external mode, `bclk_int` is a 50% duty clock with exactly 64 rising edges per word period. It is low while powered down.
- R7: If no word-clock rising edge occurs for 512 + LOSS_MARGIN master cycles, the block enters power-down within a few cycles.
- R8: External bit-clock mode (`ext_bclk` = 1) latches when 15 or more transitions of `bclk_in` fall within one word-clock half-period (between two consecutive word-clock edges). 14 transitions do not latch it.
- R9: External mode is kept even if `bclk_in` stops, and is cleared only by power-down. While it is set, `bclk_int` is held low.
- R10: During calibration or running, a `fmt_sel` value that differs from the last accepted one and is held for at least 3 word-clock rising edges starts a new calibration of CAL_PERIODS word periods. A change held for fewer edges has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock; every register in the block uses it |
| rst | input | 1 | Synchronous active-high reset |
| wclk_in | input | 1 | Word clock, asynchronous to `clk` |
| bclk_in | input | 1 | External bit clock, held low when unused |
| fmt_sel | input | 2 | Serial format select; its changes trigger calibration |
| ratio_code | output | 2 | Locked ratio: 0 none, 1 = 256, 2 = 384, 3 = 512 |
| ext_bclk | output | 1 | External bit-clock mode is latched |
| bclk_int | output | 1 | Internally generated bit clock, 64 per word period |
| pwr_down | output | 1 | Block is in power-down |
| initing | output | 1 | Initialisation phase |
| calibrating | output | 1 | Calibration phase |
| running | output | 1 | Normal operation |

## Verification
The checks assume that every gap between word-clock rising edges is at most 512 cycles plus a few, except when the clock is stopped on purpose. They also assume the external bit clock toggles no faster than once every few master cycles, so that the synchronizer sees each transition. The bench produces both clocks from master-clock-aligned counters. It changes the word period only between whole master cycles and spaces bit-clock transitions four cycles apart, starting well inside each half-period. Format changes are applied mid-period, away from word-clock edges, so the number of edges a change is held for is unambiguous.

// File: rtl/clkratio_pkg.sv
package clkratio_pkg;
  typedef enum logic [1:0] {
    RC_NONE = 2'd0,
    RC_LO   = 2'd1,
    RC_MID  = 2'd2,
    RC_HI   = 2'd3
  } ratio_e;

  typedef enum logic [1:0] {
    ST_DOWN = 2'd0,
    ST_INIT = 2'd1,
    ST_CAL  = 2'd2,
    ST_RUN  = 2'd3
  } seq_state_e;
endpackage

// File: rtl/cr_sync.sv
module cr_sync #(
  parameter int STAGES = 2,
  parameter int W      = 1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  localparam int CHAIN_W = STAGES * W;

  logic [CHAIN_W-1:0] chain;

  always_ff @(posedge clk) begin
    if (rst) chain <= '0;
    else     chain <= {chain[CHAIN_W-W-1:0], d};
  end

  assign q = chain[CHAIN_W-1 -: W];
endmodule

// File: rtl/cr_ratio_meas.sv
module cr_ratio_meas
  import clkratio_pkg::*;
#(
  parameter int RATIO_LO    = 256,
  parameter int RATIO_MID   = 384,
  parameter int RATIO_HI    = 512,
  parameter int RATIO_TOL   = 4,
  parameter int LOSS_MARGIN = 64
) (
  input  logic   clk,
  input  logic   rst,
  input  logic   wrise,
  output logic   meas_valid,
  output ratio_e meas_code,
  output logic   lost
);
  localparam int LOSS_LIMIT = RATIO_HI + LOSS_MARGIN;
  localparam int CNT_W      = $clog2(LOSS_LIMIT + 2);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(LOSS_LIMIT);

  logic [CNT_W-1:0] cnt;
  logic             have_ref;

  function automatic ratio_e classify(input int p);
    if (p >= RATIO_LO - RATIO_TOL && p <= RATIO_LO + RATIO_TOL)   return RC_LO;
    if (p >= RATIO_MID - RATIO_TOL && p <= RATIO_MID + RATIO_TOL) return RC_MID;
    if (p >= RATIO_HI - RATIO_TOL && p <= RATIO_HI + RATIO_TOL)   return RC_HI;
    return RC_NONE;
  endfunction

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt        <= '0;
      have_ref   <= 1'b0;
      meas_valid <= 1'b0;
      meas_code  <= RC_NONE;
      lost       <= 1'b0;
    end else begin
      meas_valid <= 1'b0;
      if (wrise) begin
        cnt      <= '0;
        have_ref <= 1'b1;
        lost     <= 1'b0;
        if (have_ref) begin
          meas_valid <= 1'b1;
          meas_code  <= classify(int'(cnt) + 1);
        end
      end else if (cnt == CNT_LAST) begin
        lost     <= 1'b1;
        have_ref <= 1'b0;
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/cr_bclk_ctl.sv
module cr_bclk_ctl
  import clkratio_pkg::*;
#(
  parameter int RATIO_LO      = 256,
  parameter int RATIO_MID     = 384,
  parameter int RATIO_HI      = 512,
  parameter int BCLK_PER_WORD = 64,
  parameter int EXT_EDGES     = 15
) (
  input  logic   clk,
  input  logic   rst,
  input  logic   wrise,
  input  logic   wedge,
  input  logic   bedge,
  input  logic   pwr_down,
  input  ratio_e lock_code,
  output logic   ext_mode,
  output logic   bclk_int
);
  localparam int EW      = $clog2(EXT_EDGES + 1);
  localparam int HALF_LO  = RATIO_LO  / (2 * BCLK_PER_WORD);
  localparam int HALF_MID = RATIO_MID / (2 * BCLK_PER_WORD);
  localparam int HALF_HI  = RATIO_HI  / (2 * BCLK_PER_WORD);
  localparam int HW      = $clog2(HALF_HI + 1);
  localparam logic [EW-1:0] ECNT_LAST = EW'(EXT_EDGES - 1);

  logic [EW-1:0] ecnt;
  logic [HW-1:0] hcnt;
  logic [HW-1:0] half_last;

  always_comb begin
    case (lock_code)
      RC_MID:  half_last = HW'(HALF_MID - 1);
      RC_HI:   half_last = HW'(HALF_HI - 1);
      default: half_last = HW'(HALF_LO - 1);
    endcase
  end

  // transitions counted per word-clock half-period; mode is sticky
  always_ff @(posedge clk) begin
    if (rst || pwr_down) begin
      ext_mode <= 1'b0;
      ecnt     <= '0;
    end else if (wedge) begin
      ecnt <= '0;
    end else if (bedge) begin
      if (ecnt == ECNT_LAST) ext_mode <= 1'b1;
      else                   ecnt     <= ecnt + 1'b1;
    end
  end

  // internal bit clock, phase restarted on every word-clock rise
  always_ff @(posedge clk) begin
    if (rst || pwr_down || ext_mode || wrise) begin
      hcnt     <= '0;
      bclk_int <= 1'b0;
    end else if (hcnt == half_last) begin
      hcnt     <= '0;
      bclk_int <= ~bclk_int;
    end else begin
      hcnt <= hcnt + 1'b1;
    end
  end
endmodule

// File: rtl/cr_fmt_watch.sv
module cr_fmt_watch #(
  parameter int W    = 2,
  parameter int HOLD = 3
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] fmt_s,
  input  logic         wrise,
  input  logic         pwr_down,
  output logic         cal_req
);
  localparam int HCW = $clog2(HOLD + 1);
  localparam logic [HCW-1:0] HOLD_LAST = HCW'(HOLD - 1);

  logic [W-1:0]   accepted;
  logic [W-1:0]   fmt_d;
  logic [HCW-1:0] hcnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      accepted <= '0;
      fmt_d    <= '0;
      hcnt     <= '0;
      cal_req  <= 1'b0;
    end else begin
      fmt_d   <= fmt_s;
      cal_req <= 1'b0;
      if (pwr_down) begin
        accepted <= fmt_s;
        hcnt     <= '0;
      end else if (fmt_s == accepted || fmt_s != fmt_d) begin
        hcnt <= '0;
      end else if (wrise) begin
        if (hcnt == HOLD_LAST) begin
          cal_req  <= 1'b1;
          accepted <= fmt_s;
          hcnt     <= '0;
        end else begin
          hcnt <= hcnt + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/clkratio_seq.sv
module clkratio_seq
  import clkratio_pkg::*;
#(
  parameter int RATIO_LO      = 256,
  parameter int RATIO_MID     = 384,
  parameter int RATIO_HI      = 512,
  parameter int RATIO_TOL     = 4,
  parameter int LOSS_MARGIN   = 64,
  parameter int BCLK_PER_WORD = 64,
  parameter int EXT_EDGES     = 15,
  parameter int FMT_W         = 2,
  parameter int FMT_HOLD      = 3,
  parameter int INIT_PERIODS  = 2432,
  parameter int CAL_PERIODS   = 268,
  parameter int SYNC_STAGES   = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wclk_in,
  input  logic             bclk_in,
  input  logic [FMT_W-1:0] fmt_sel,
  output logic [1:0]       ratio_code,
  output logic             ext_bclk,
  output logic             bclk_int,
  output logic             pwr_down,
  output logic             initing,
  output logic             calibrating,
  output logic             running
);
  localparam int PMAX   = (INIT_PERIODS > CAL_PERIODS) ? INIT_PERIODS : CAL_PERIODS;
  localparam int PCNT_W = $clog2(PMAX + 1);
  localparam logic [PCNT_W-1:0] INIT_LAST = PCNT_W'(INIT_PERIODS - 1);
  localparam logic [PCNT_W-1:0] CAL_LAST  = PCNT_W'(CAL_PERIODS - 1);

  logic [FMT_W+1:0]  sync_q;
  logic              wclk_s, bclk_s, wclk_d, bclk_d;
  logic [FMT_W-1:0]  fmt_s;
  logic              wrise, wedge, bedge;
  logic              meas_valid, lost, cal_req, fault;
  ratio_e            meas_code, lock_code;
  seq_state_e        state;
  logic [PCNT_W-1:0] pcnt;

  cr_sync #(.STAGES(SYNC_STAGES), .W(FMT_W + 2)) u_sync (
    .clk(clk), .rst(rst), .d({fmt_sel, bclk_in, wclk_in}), .q(sync_q)
  );

  assign wclk_s = sync_q[0];
  assign bclk_s = sync_q[1];
  assign fmt_s  = sync_q[FMT_W+1:2];

  always_ff @(posedge clk) begin
    if (rst) begin
      wclk_d <= 1'b0;
      bclk_d <= 1'b0;
    end else begin
      wclk_d <= wclk_s;
      bclk_d <= bclk_s;
    end
  end

  assign wrise = wclk_s & ~wclk_d;
  assign wedge = wclk_s ^ wclk_d;
  assign bedge = bclk_s ^ bclk_d;

  cr_ratio_meas #(
    .RATIO_LO(RATIO_LO), .RATIO_MID(RATIO_MID), .RATIO_HI(RATIO_HI),
    .RATIO_TOL(RATIO_TOL), .LOSS_MARGIN(LOSS_MARGIN)
  ) u_meas (
    .clk(clk), .rst(rst), .wrise(wrise),
    .meas_valid(meas_valid), .meas_code(meas_code), .lost(lost)
  );

  cr_bclk_ctl #(
    .RATIO_LO(RATIO_LO), .RATIO_MID(RATIO_MID), .RATIO_HI(RATIO_HI),
    .BCLK_PER_WORD(BCLK_PER_WORD), .EXT_EDGES(EXT_EDGES)
  ) u_bclk (
    .clk(clk), .rst(rst), .wrise(wrise), .wedge(wedge), .bedge(bedge),
    .pwr_down(pwr_down), .lock_code(lock_code),
    .ext_mode(ext_bclk), .bclk_int(bclk_int)
  );

  cr_fmt_watch #(.W(FMT_W), .HOLD(FMT_HOLD)) u_fmt (
    .clk(clk), .rst(rst), .fmt_s(fmt_s), .wrise(wrise),
    .pwr_down(pwr_down), .cal_req(cal_req)
  );

  assign fault = lost || (meas_valid && (meas_code != lock_code));

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_DOWN;
      lock_code <= RC_NONE;
      pcnt      <= '0;
    end else begin
      case (state)
        ST_DOWN: begin
          pcnt <= '0;
          if (meas_valid && meas_code != RC_NONE) begin
            state     <= ST_INIT;
            lock_code <= meas_code;
          end
        end
        ST_INIT: begin
          if (fault) begin
            state     <= ST_DOWN;
            lock_code <= RC_NONE;
          end else if (meas_valid) begin
            if (pcnt == INIT_LAST) begin
              state <= ST_CAL;
              pcnt  <= '0;
            end else begin
              pcnt <= pcnt + 1'b1;
            end
          end
        end
        ST_CAL: begin
          if (fault) begin
            state     <= ST_DOWN;
            lock_code <= RC_NONE;
          end else if (cal_req) begin
            pcnt <= '0;
          end else if (meas_valid) begin
            if (pcnt == CAL_LAST) begin
              state <= ST_RUN;
              pcnt  <= '0;
            end else begin
              pcnt <= pcnt + 1'b1;
            end
          end
        end
        default: begin
          if (fault) begin
            state     <= ST_DOWN;
            lock_code <= RC_NONE;
          end else if (cal_req) begin
            state <= ST_CAL;
            pcnt  <= '0;
          end
        end
      endcase
    end
  end

  assign ratio_code  = lock_code;
  assign pwr_down    = (state == ST_DOWN);
  assign initing     = (state == ST_INIT);
  assign calibrating = (state == ST_CAL);
  assign running     = (state == ST_RUN);
endmodule

// File: rtl/clkratio_seq_chk.sv
module clkratio_seq_chk #(
  parameter int LOSS_LIMIT  = 576,
  parameter int SYNC_STAGES = 2
) (
  input logic       clk,
  input logic       rst,
  input logic       wclk_in,
  input logic [1:0] ratio_code,
  input logic       ext_bclk,
  input logic       bclk_int,
  input logic       pwr_down,
  input logic       initing,
  input logic       calibrating,
  input logic       running
);
  localparam int IDLE_MAX = LOSS_LIMIT + SYNC_STAGES + 8;
  localparam int IW       = $clog2(IDLE_MAX + 2);

  logic          wclk_q;
  logic [IW-1:0] idle;

  always_ff @(posedge clk) begin
    if (rst) begin
      wclk_q <= 1'b0;
      idle   <= '0;
    end else begin
      wclk_q <= wclk_in;
      if (wclk_in && !wclk_q)          idle <= '0;
      else if (idle != IW'(IDLE_MAX + 1)) idle <= idle + 1'b1;
    end
  end

  a_r1_down_no_ratio: assert property (@(posedge clk) disable iff (rst)
    pwr_down |-> (ratio_code == 2'd0));

  a_r2_code_held: assert property (@(posedge clk) disable iff (rst)
    (!pwr_down && $past(!pwr_down)) |-> $stable(ratio_code));

  a_r3_init_from_down: assert property (@(posedge clk) disable iff (rst)
    $rose(initing) |-> $past(pwr_down));

  a_r3_run_from_cal: assert property (@(posedge clk) disable iff (rst)
    $rose(running) |-> $past(calibrating));

  a_r10_cal_entry: assert property (@(posedge clk) disable iff (rst)
    $rose(calibrating) |-> ($past(initing) || $past(running)));

  a_r7_loss_down: assert property (@(posedge clk) disable iff (rst)
    (int'(idle) > IDLE_MAX) |-> pwr_down);

  a_r9_ext_sticky: assert property (@(posedge clk) disable iff (rst)
    (ext_bclk && !pwr_down) |=> ext_bclk);

  a_r9_bclk_quiet: assert property (@(posedge clk) disable iff (rst)
    (ext_bclk && $past(ext_bclk)) |-> !bclk_int);
endmodule

bind clkratio_seq clkratio_seq_chk #(
  .LOSS_LIMIT(RATIO_HI + LOSS_MARGIN),
  .SYNC_STAGES(SYNC_STAGES)
) u_chk (
  .clk(clk), .rst(rst), .wclk_in(wclk_in), .ratio_code(ratio_code),
  .ext_bclk(ext_bclk), .bclk_int(bclk_int), .pwr_down(pwr_down),
  .initing(initing), .calibrating(calibrating), .running(running)
);

// File: tb/clkratio_seq_test.sv
`timescale 1ns/1ps
module clkratio_seq_test;
  localparam int INIT_P = 6;
  localparam int CAL_P  = 4;
  localparam int LOSS_WAIT = 512 + 64 + 24;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       wclk = 1'b0;
  logic       bclk = 1'b0;
  logic [1:0] fmt = 2'd0;
  logic [1:0] ratio_code;
  logic       ext_bclk, bclk_int, pwr_down, initing, calibrating, running;

  int nchk = 0;
  int nfail = 0;
  int per = 256;
  bit wen = 1'b0;
  int wc = 0;
  int bmode = 0;
  int bn = 0;
  int init_rises = 0;
  int cal_rises = 0;
  bit saw_down = 1'b0;
  bit saw_cal = 1'b0;

  always #2.5 clk = ~clk;

  clkratio_seq #(.INIT_PERIODS(INIT_P), .CAL_PERIODS(CAL_P)) uut (
    .clk(clk), .rst(rst), .wclk_in(wclk), .bclk_in(bclk), .fmt_sel(fmt),
    .ratio_code(ratio_code), .ext_bclk(ext_bclk), .bclk_int(bclk_int),
    .pwr_down(pwr_down), .initing(initing), .calibrating(calibrating),
    .running(running)
  );

  // stimulus clocks, stepped on the falling master edge
  always @(negedge clk) begin : gen
    int ph;
    if (!wen) begin
      wc   <= 0;
      wclk <= 1'b0;
      ph = 0;
    end else begin
      if (wc >= per - 1) wc <= 0;
      else               wc <= wc + 1;
      wclk <= (wc < per / 2);
      ph = (wc < per / 2) ? wc : wc - per / 2;
    end
    case (bmode)
      1: if (wc % 4 == 0) bclk <= ~bclk;
      2: if (wen && ph >= 20 && ph < 20 + 4 * bn && (ph - 20) % 4 == 0) bclk <= ~bclk;
      default: bclk <= 1'b0;
    endcase
  end

  always @(posedge wclk) begin
    if (initing)     init_rises = init_rises + 1;
    if (calibrating) cal_rises  = cal_rises + 1;
  end

  always @(negedge clk) begin
    if (pwr_down)    saw_down = 1'b1;
    if (calibrating) saw_cal  = 1'b1;
  end

  task automatic chk(input string req, input int act, input int exp);
    nchk++;
    if (act != exp) begin
      nfail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic rises(input int n);
    repeat (n) @(posedge wclk);
    @(negedge clk);
  endtask

  task automatic cycles(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic t_reset;
    rst = 1'b1;
    cycles(10);
    chk("R1 reset pwr_down", pwr_down, 1);
    chk("R1 reset ratio", ratio_code, 0);
    chk("R1 reset ext", ext_bclk, 0);
    chk("R1 reset bclk_int", bclk_int, 0);
    chk("R1 reset running", running, 0);
    rst = 1'b0;
    cycles(3000);
    chk("R1 no word clock stays down", pwr_down, 1);
    chk("R6 bclk_int low in power-down", bclk_int, 0);
  endtask

  task automatic t_start(input int p, input int code, input string tag);
    per = p;
    init_rises = 0;
    cal_rises = 0;
    wen = 1'b1;
    rises(INIT_P + CAL_P + 4);
    chk({tag, " running"}, running, 1);
    chk({tag, " ratio code"}, ratio_code, code);
    chk("R3 init periods", init_rises, INIT_P);
    chk("R3 cal periods", cal_rises, CAL_P);
  endtask

  task automatic t_loss;
    wen = 1'b0;
    cycles(LOSS_WAIT);
    chk("R7 loss enters power-down", pwr_down, 1);
    chk("R7 loss clears ratio", ratio_code, 0);
  endtask

  task automatic t_bclk(input int p);
    int cnt = 0;
    logic prev = bclk_int;
    int highs = 0;
    for (int i = 0; i < 10 * p; i++) begin
      @(negedge clk);
      if (bclk_int && !prev) cnt++;
      if (bclk_int) highs++;
      prev = bclk_int;
    end
    chk("R6 internal bit clock edges", cnt, 640);
    chk("R6 internal bit clock duty", highs, 5 * p);
  endtask

  task automatic t_ratio_change;
    per = 256;
    saw_down = 1'b0;
    init_rises = 0;
    cal_rises = 0;
    rises(INIT_P + CAL_P + 6);
    chk("R5 change forced power-down", saw_down, 1);
    chk("R5 relocked ratio", ratio_code, 1);
    chk("R5 running after relock", running, 1);
    chk("R5 relock init periods", init_rises, INIT_P);
  endtask

  task automatic t_tolerance;
    t_start(259, 1, "R4 within tolerance");
    t_loss();
    per = 300;
    wen = 1'b1;
    saw_cal = 1'b0;
    rises(20);
    chk("R4 invalid ratio stays down", pwr_down, 1);
    chk("R4 invalid ratio no code", ratio_code, 0);
    t_loss();
  endtask

  task automatic t_ext;
    t_start(256, 1, "R8 setup");
    bn = 14;
    bmode = 2;
    rises(10);
    chk("R8 14 transitions no external mode", ext_bclk, 0);
    bn = 15;
    rises(4);
    chk("R8 15 transitions external mode", ext_bclk, 1);
    chk("R9 bclk_int held low", bclk_int, 0);
    bmode = 0;
    rises(10);
    chk("R9 external mode sticky", ext_bclk, 1);
    chk("R9 still running", running, 1);
    t_loss();
    chk("R9 power-down clears external mode", ext_bclk, 0);
  endtask

  task automatic t_fmt;
    t_start(256, 1, "R10 setup");
    @(posedge wclk);
    cycles(100);
    saw_cal = 1'b0;
    fmt = 2'd1;
    @(posedge wclk);
    @(posedge wclk);
    cycles(100);
    fmt = 2'd0;
    rises(6);
    chk("R10 short change ignored", saw_cal, 0);
    chk("R10 still running", running, 1);
    @(posedge wclk);
    cycles(100);
    cal_rises = 0;
    fmt = 2'd2;
    rises(CAL_P + 5);
    chk("R10 held change calibrates", saw_cal, 1);
    chk("R10 calibration length", cal_rises, CAL_P);
    chk("R10 back to running", running, 1);
    t_loss();
  endtask

  initial begin : watchdog
    repeat (180000) @(posedge clk);
    nfail++;
    $display("FAIL watchdog actual=timeout expected=completion");
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

  initial begin : main
    t_reset();
    t_start(256, 1, "R2 ratio 256");
    t_bclk(256);
    t_loss();
    t_start(384, 2, "R2 ratio 384");
    t_bclk(384);
    t_loss();
    t_start(512, 3, "R2 ratio 512");
    t_bclk(512);
    t_ratio_change();
    t_loss();
    t_tolerance();
    t_ext();
    t_fmt();
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end
endmodule